// File: doc/BRIEF.md
# Oscillator-Count Thermal Level Monitor

This block is one channel of an on-die temperature monitor. It does not measure temperature directly. A ring oscillator whose frequency rises with die temperature drives the `osc_in` pin. The block samples that signal through a synchronizer and counts its rising edges. Each count is taken over a window of N reference clocks, and a new window starts every M reference clocks. When a window closes, the count is published with a valid flag. The count is also compared against three programmable thresholds, which gives a thermal level from 0 to 3. A larger count means a hotter die.

The level drives three outputs. Level 1 is a point for software-managed cooling. Level 2 can request that the core clock be halved. Level 3 can request an emergency shutdown from power management. Each interrupt source, and each of the two hardware actions, has its own enable bit.

Out of reset the channel counts nothing until both M and N are programmed. A stop bit pauses the channel and holds its last result. Software reads and writes the block through a small word-addressed register interface.

Top module: `thermal_level_monitor`

## Requirements
- R1: After reset, register word 0 (configuration) reads 0, word 1 reads 0xFFFFFFFF, word 2 reads 0x0000FFFF, words 3 and 4 read 0, and `irq`, `clk_halve_req` and `shutdown_req` are low.
- R2: While the period field M (word 0 bits 23:8) or the window field N (word 0 bits 31:24) is zero, no measurement completes and the valid flag (word 3 bit 9) stays 0.
- R3: A measurement counts the synchronized rising edges of `osc_in` during the first N clocks of every M-clock period; the window is cut to M clocks when N > M. The result appears in word 4 bits 31:16 and sets valid (word 3 bit 9).
- R4: The edge counter saturates at its all-ones value. A saturated window reports 0xFFFF in word 4 bits 31:16 and state code 5 in word 3 bits 2:0.
- R5: The level is the highest n in 1..3 for which the count is at or above threshold n; it is 0 when no threshold is met. Threshold 1 is word 1 bits 15:0, threshold 2 is word 1 bits 31:16 and threshold 3 is word 2 bits 15:0. The level is reported as the state in word 3 bits 2:0 when there is no overflow, and it changes only when a window completes.
- R6: The pending flag (word 3 bit 8) is set when a completed window makes the level cross upward to at least 1, 2 or 3, provided that level's enable is set (word 0 bit 3, bit 5 and bit 6 respectively). It is also set on a new overflow when word 0 bit 4 is set. `irq` follows the pending flag.
- R7: A fall in level never sets the pending flag.
- R8: Writing word 3 with bit 8 set clears the pending flag. Writing 0 to that bit, and writing any other status bit, has no effect.
- R9: `clk_halve_req` is high exactly when the level is 2 or more and word 0 bit 1 is set.
- R10: `shutdown_req` is high exactly when the level is 3 and word 0 bit 2 is set.
- R11: Setting word 0 bit 0 (stop) halts measurement and leaves the last result, the level and the state unchanged. Clearing it restarts measurement with a fresh period.
- R12: Word 0 reads back as written with bit 7 forced to 0. Word 1 reads back as written, and word 2 reads back only its low 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Temperature-dependent oscillator, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (0..4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request, level-sensitive |
| clk_halve_req | output | 1 | Request to halve the core clock |
| shutdown_req | output | 1 | Emergency shutdown request |

## Verification
A wrong period or window position shows up as a published count that is off by a whole number of oscillator periods. It is visible in word 4 from the first window that closes after the channel is restarted, so within N + 3 clocks. A corrupted level register shows up at once on `clk_halve_req` and `shutdown_req` and in the state field. A bad crossing memory shows up instead as a missing or spurious `irq` after the next window closes. The bench pins these down by choosing oscillator periods that divide N exactly, which makes each count independent of the oscillator's phase.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned PER_W   = 16;
  localparam int unsigned WIN_W   = 8;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned NUM_TH  = 3;
  localparam int unsigned LVL_W   = 2;

  localparam logic [ADDR_W-1:0] ADR_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_THA  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_THB  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd4;

  localparam int unsigned PEND_BIT  = 8;
  localparam int unsigned VALID_BIT = 9;
  localparam logic [2:0]  ST_OVF    = 3'd5;

  typedef struct packed {
    logic [WIN_W-1:0] win_len;
    logic [PER_W-1:0] period;
    logic             spare;
    logic             irq_l3;
    logic             irq_l2;
    logic             irq_ovf;
    logic             irq_l1;
    logic             shut_en;
    logic             halve_en;
    logic             stop;
  } cfg_t;
endpackage

// File: rtl/tlm_osc_sync.sv
module tlm_osc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], osc_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tlm_window_timer.sv
module tlm_window_timer #(
  parameter int unsigned PER_W = 16,
  parameter int unsigned WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             first_o,
  output logic             open_o,
  output logic             done_o
);
  logic [PER_W-1:0] pos_q, pos_d;
  logic [PER_W-1:0] win_ext, last_pos, per_last;

  always_comb begin
    win_ext  = PER_W'(win_len_i);
    per_last = period_i - PER_W'(1);
    last_pos = (win_ext < period_i) ? (win_ext - PER_W'(1)) : per_last;
    if (!run_i)                 pos_d = '0;
    else if (pos_q >= per_last) pos_d = '0;
    else                        pos_d = pos_q + PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign first_o = run_i && (pos_q == '0);
  assign open_o  = run_i && (pos_q < win_ext);
  assign done_o  = run_i && (pos_q == last_pos);
endmodule

// File: rtl/tlm_edge_counter.sv
module tlm_edge_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_i,
  input  logic             open_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, base;
  logic             cnt_en;

  always_comb begin
    base = first_i ? '0 : cnt_q;
    if (open_i && rise_i && (base != CNT_MAX)) cnt_next_o = base + CNT_W'(1);
    else                                       cnt_next_o = base;
    sat_o  = (cnt_next_o == CNT_MAX);
    cnt_en = open_i | first_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_next_o;
  end
endmodule

// File: rtl/tlm_level_eval.sv
module tlm_level_eval #(
  parameter int unsigned VAL_W  = 16,
  parameter int unsigned NUM_TH = 3,
  parameter int unsigned LVL_W  = 2
) (
  input  logic [VAL_W-1:0]             value_i,
  input  logic [NUM_TH-1:0][VAL_W-1:0] th_i,
  output logic [LVL_W-1:0]             level_o
);
  logic [NUM_TH-1:0] hit;

  for (genvar g = 0; g < NUM_TH; g++) begin : g_cmp
    assign hit[g] = (value_i >= th_i[g]);
  end

  always_comb begin
    level_o = '0;
    for (int k = 0; k < NUM_TH; k++) begin
      if (hit[k]) level_o = LVL_W'(k + 1);
    end
  end
endmodule

// File: rtl/thermal_level_monitor.sv
module thermal_level_monitor
  import tlm_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              clk_halve_req,
  output logic              shutdown_req
);
  cfg_t                           cfg_q, cfg_d;
  logic [NUM_TH-1:0][FIELD_W-1:0] th_q, th_d;
  logic                           cfg_wr, tha_wr, thb_wr;

  logic                           timing_set, run;
  logic                           win_first, win_open, win_done;
  logic                           osc_rise;
  logic [CNT_W-1:0]               cnt_next;
  logic                           cnt_sat;
  logic [FIELD_W-1:0]             meas_field;
  logic [LVL_W-1:0]               new_level;

  logic [FIELD_W-1:0]             res_q;
  logic [LVL_W-1:0]               level_q;
  logic                           ovf_q, valid_q, valid_d, pend_q, pend_d;
  logic [NUM_TH-1:0]              crossed, lvl_irq_en;
  logic                           pend_set, pend_clr;
  logic [2:0]                     state_code;

  // register write decode
  always_comb begin
    cfg_wr = reg_we && (reg_addr == ADR_CFG);
    tha_wr = reg_we && (reg_addr == ADR_THA);
    thb_wr = reg_we && (reg_addr == ADR_THB);
    cfg_d  = cfg_t'(reg_wdata);
    cfg_d.spare = 1'b0;
    th_d   = th_q;
    if (tha_wr) begin
      th_d[0] = reg_wdata[FIELD_W-1:0];
      th_d[1] = reg_wdata[REG_W-1:FIELD_W];
    end
    if (thb_wr) th_d[2] = reg_wdata[FIELD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                th_q <= '1;
    else if (tha_wr || thb_wr) th_q <= th_d;
  end

  // measurement path
  assign timing_set = (cfg_q.period != '0) && (cfg_q.win_len != '0);
  assign run        = timing_set && !cfg_q.stop;

  tlm_osc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_i  (osc_in),
    .rise_o (osc_rise)
  );

  tlm_window_timer #(.PER_W(PER_W), .WIN_W(WIN_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .period_i  (cfg_q.period),
    .win_len_i (cfg_q.win_len),
    .first_o   (win_first),
    .open_o    (win_open),
    .done_o    (win_done)
  );

  tlm_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .first_i    (win_first),
    .open_i     (win_open),
    .rise_i     (osc_rise),
    .cnt_next_o (cnt_next),
    .sat_o      (cnt_sat)
  );

  assign meas_field = cnt_sat ? '1 : FIELD_W'(cnt_next);

  tlm_level_eval #(.VAL_W(FIELD_W), .NUM_TH(NUM_TH), .LVL_W(LVL_W)) u_eval (
    .value_i (meas_field),
    .th_i    (th_q),
    .level_o (new_level)
  );

  // upward crossing detection per level
  assign lvl_irq_en = {cfg_q.irq_l3, cfg_q.irq_l2, cfg_q.irq_l1};
  for (genvar k = 0; k < NUM_TH; k++) begin : g_cross
    assign crossed[k] = (new_level >= LVL_W'(k + 1)) && (level_q < LVL_W'(k + 1));
  end

  always_comb begin
    pend_set = win_done &&
               ((|(crossed & lvl_irq_en)) || (cnt_sat && !ovf_q && cfg_q.irq_ovf));
    pend_clr = reg_we && (reg_addr == ADR_STAT) && reg_wdata[PEND_BIT];
    pend_d   = pend_set | (pend_q & ~pend_clr);
    if (!timing_set)   valid_d = 1'b0;
    else if (win_done) valid_d = 1'b1;
    else               valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      level_q <= '0;
      ovf_q   <= 1'b0;
    end else if (win_done) begin
      res_q   <= meas_field;
      level_q <= new_level;
      ovf_q   <= cnt_sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      pend_q  <= pend_d;
    end
  end

  // outputs and read mux
  assign state_code    = ovf_q ? ST_OVF : 3'(level_q);
  assign irq           = pend_q;
  assign clk_halve_req = cfg_q.halve_en && (level_q >= LVL_W'(2));
  assign shutdown_req  = cfg_q.shut_en && (level_q == LVL_W'(3));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CFG:  reg_rdata = cfg_q;
      ADR_THA:  reg_rdata = {th_q[1], th_q[0]};
      ADR_THB:  reg_rdata = {{(REG_W-FIELD_W){1'b0}}, th_q[2]};
      ADR_STAT: begin
        reg_rdata[2:0]       = state_code;
        reg_rdata[PEND_BIT]  = pend_q;
        reg_rdata[VALID_BIT] = valid_q;
      end
      ADR_CNT:  reg_rdata = {res_q, {(REG_W-FIELD_W){1'b0}}};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tlm_checker.sv
module tlm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        win_done,
  input logic        valid_q,
  input logic        pend_q,
  input logic [1:0]  level_q,
  input logic        ovf_q,
  input logic [15:0] res_q,
  input logic        stop,
  input logic        clk_halve_req,
  input logic        shutdown_req,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic        wbit8
);
  // R5: level moves only on window completion
  p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_done |=> $stable(level_q));

  // R3: valid rises only after a window closed
  p_valid_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(win_done));

  // R4: overflow state always publishes the all-ones count
  p_ovf_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (res_q == 16'hFFFF));

  // R6: pending is raised only by a completed window
  p_pend_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(win_done));

  // R8: pending drops only after a write-one to the status word
  p_pend_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(reg_we && (reg_addr == 3'd3) && wbit8));

  // R9: halve request starts only after a window or a config write
  p_halve_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_halve_req) |-> ($past(win_done) || $past(reg_we && (reg_addr == 3'd0))));

  // R10: shutdown request starts only after a window or a config write
  p_shut_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_req) |-> ($past(win_done) || $past(reg_we && (reg_addr == 3'd0))));

  // R11: a stopped channel leaves its result untouched
  p_stop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> $stable(res_q));
endmodule

bind thermal_level_monitor tlm_checker u_tlm_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .win_done      (win_done),
  .valid_q       (valid_q),
  .pend_q        (pend_q),
  .level_q       (level_q),
  .ovf_q         (ovf_q),
  .res_q         (res_q),
  .stop          (cfg_q.stop),
  .clk_halve_req (clk_halve_req),
  .shutdown_req  (shutdown_req),
  .reg_we        (reg_we),
  .reg_addr      (reg_addr),
  .wbit8         (reg_wdata[8])
);

// File: tb/test_thermal_level_monitor.sv
module test_thermal_level_monitor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        osc_in;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq, clk_halve_req, shutdown_req;

  int n_chk  = 0;
  int n_fail = 0;
  int hp     = 0;

  localparam logic [15:0] PER       = 16'd300;
  localparam logic [7:0]  FLAGS_ALL = 8'h7E;

  // {half period, N, count, state, 5'b0, pend, halve, shut}
  localparam logic [47:0] VEC [8] = '{
    {8'd0, 8'd100, 16'd0,     8'd0, 8'b000},
    {8'd4, 8'd80,  16'd10,    8'd0, 8'b000},
    {8'd2, 8'd96,  16'd24,    8'd1, 8'b100},
    {8'd1, 8'd100, 16'd50,    8'd2, 8'b110},
    {8'd1, 8'd130, 16'd65,    8'd3, 8'b111},
    {8'd1, 8'd254, 16'hFFFF,  8'd5, 8'b111},
    {8'd3, 8'd120, 16'd20,    8'd1, 8'b000},
    {8'd2, 8'd160, 16'd40,    8'd2, 8'b110}
  };

  thermal_level_monitor #(.CNT_W(7)) i_thermal_level_monitor (
    .clk           (clk),
    .rst_n         (rst_n),
    .osc_in        (osc_in),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .irq           (irq),
    .clk_halve_req (clk_halve_req),
    .shutdown_req  (shutdown_req)
  );

  always #5 clk = ~clk;

  // oscillator model: toggles every hp clocks, idle when hp is 0
  initial begin
    osc_in = 1'b0;
    forever begin
      if (hp == 0) @(negedge clk);
      else begin
        repeat (hp) @(negedge clk);
        osc_in = ~osc_in;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // stop, retune oscillator, clear pending, restart and let two periods pass
  task automatic run_point(input int h, input logic [7:0] n, input logic [7:0] flags);
    wr(3'd0, {n, PER, flags | 8'h01});
    hp = h;
    repeat (20) @(negedge clk);
    wr(3'd3, 32'h100);
    wr(3'd0, {n, PER, flags});
    repeat (650) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, d); chk("R1 config word", d, 32'h0);
    rd(3'd1, d); chk("R1 threshold word 1", d, 32'hFFFF_FFFF);
    rd(3'd2, d); chk("R1 threshold word 2", d, 32'h0000_FFFF);
    rd(3'd3, d); chk("R1 status word", d, 32'h0);
    rd(3'd4, d); chk("R1 count word", d, 32'h0);
    chk("R1 outputs", {29'b0, irq, clk_halve_req, shutdown_req}, 32'h0);

    // R2 no measurement until timing programmed
    hp = 1;
    repeat (400) @(negedge clk);
    rd(3'd3, d); chk("R2 valid with M,N zero", {31'b0, d[9]}, 32'h0);
    wr(3'd0, {8'd0, PER, 8'h00});
    repeat (400) @(negedge clk);
    rd(3'd3, d); chk("R2 valid with N zero", {31'b0, d[9]}, 32'h0);

    // R12 register readback
    wr(3'd1, {16'd40, 16'd20});
    wr(3'd2, {16'hABCD, 16'd60});
    rd(3'd1, d); chk("R12 threshold word 1", d, 32'h0028_0014);
    rd(3'd2, d); chk("R12 threshold word 2", d, 32'h0000_003C);
    wr(3'd0, {8'd100, PER, 8'hFF});
    rd(3'd0, d); chk("R12 config spare bit", d, {8'd100, PER, 8'h7F});

    // vector table: R3 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < 8; i++) begin
      logic [47:0] v;
      v = VEC[i];
      run_point(int'(v[47:40]), v[39:32], FLAGS_ALL);
      rd(3'd4, d); chk($sformatf("R3 count vec%0d", i), d, {v[31:16], 16'h0});
      rd(3'd3, d);
      chk($sformatf("R5 R4 state vec%0d", i), {29'b0, d[2:0]}, {29'b0, v[10:8]});
      chk($sformatf("R3 valid vec%0d", i), {31'b0, d[9]}, 32'h1);
      chk($sformatf("R6 R7 pending vec%0d", i), {31'b0, d[8]}, {31'b0, v[2]});
      chk($sformatf("R6 irq vec%0d", i), {31'b0, irq}, {31'b0, v[2]});
      chk($sformatf("R9 halve vec%0d", i), {31'b0, clk_halve_req}, {31'b0, v[1]});
      chk($sformatf("R10 shutdown vec%0d", i), {31'b0, shutdown_req}, {31'b0, v[0]});
    end

    // R11 stop holds result, clearing restarts
    wr(3'd0, {8'd160, PER, 8'h7F});
    hp = 1;
    repeat (800) @(negedge clk);
    rd(3'd4, d); chk("R11 count held while stopped", d, {16'd40, 16'h0});
    rd(3'd3, d); chk("R11 state held while stopped", {29'b0, d[2:0]}, 32'd2);
    wr(3'd0, {8'd160, PER, FLAGS_ALL});
    repeat (650) @(negedge clk);
    rd(3'd4, d); chk("R11 count after resume", d, {16'd80, 16'h0});

    // R8 write-one-to-clear
    rd(3'd3, d); chk("R8 pending before clear", d, 32'h0000_0303);
    wr(3'd3, 32'h0);
    rd(3'd3, d); chk("R8 zero write ignored", d, 32'h0000_0303);
    wr(3'd3, 32'hFFFF_FEFF);
    rd(3'd3, d); chk("R8 other bits ignored", d, 32'h0000_0303);
    wr(3'd3, 32'h0000_0100);
    rd(3'd3, d); chk("R8 pending cleared", d, 32'h0000_0203);
    chk("R8 irq low after clear", {31'b0, irq}, 32'h0);

    // R6 R9 R10 enables gate everything
    run_point(0, 8'd160, 8'h00);
    rd(3'd3, d); chk("R5 cold with enables off", {29'b0, d[2:0]}, 32'd0);
    run_point(1, 8'd160, 8'h00);
    rd(3'd3, d); chk("R5 hot with enables off", {29'b0, d[2:0]}, 32'd3);
    chk("R6 level irq disabled", {31'b0, d[8]}, 32'h0);
    chk("R9 halve disabled", {31'b0, clk_halve_req}, 32'h0);
    chk("R10 shutdown disabled", {31'b0, shutdown_req}, 32'h0);

    // R4 R6 overflow source on its own
    run_point(1, 8'd254, 8'h10);
    rd(3'd4, d); chk("R4 saturated count", d, 32'hFFFF_0000);
    rd(3'd3, d); chk("R4 overflow state", {29'b0, d[2:0]}, 32'd5);
    chk("R6 overflow irq", {31'b0, irq}, 32'h1);

    // R9 R10 halve only
    wr(3'd0, {8'd254, PER, 8'h02});
    chk("R9 halve enabled at level 3", {31'b0, clk_halve_req}, 32'h1);
    chk("R10 shutdown off when not enabled", {31'b0, shutdown_req}, 32'h0);

    summary();
    $finish;
  end
endmodule